// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is one bank of general-purpose pins that is controlled through a small register map on a synchronous write bus. Each pin can be made an input or an output. Output levels are changed only by write-one-to-set and write-one-to-clear strobes, so several pins can change without a read-modify-write. Every pin has its own control word. That word holds the direction bit and a 2-bit edge-trigger code.

Edges on the already-synchronised input pins are recorded in an interrupt status register. The bank raises a single interrupt line while any recorded, unmasked edge is present. Masking uses two separate registers, one that sets mask bits and one that clears them. An external lock unit supplies a bank write-enable, and no write is accepted while it is low. Reads are combinational from the address.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, all outputs read 0 at offset 0x00, every pin is an input (control bit 0 = 1, `pin_oe` all zero), every mask bit reads 1 at 0x0A0, all status bits read 0 at 0x080, all trigger codes are 0, and `irq` is low.
- R2: The control word for pin p sits at offset 0x100 + 4*p. Its bit 0 selects the direction (1 = input, 0 = output) and bits [4:3] hold the trigger code. The word reads back as those three bits with all other bits 0, and `pin_oe[p]` is the inverse of the direction bit.
- R3: A write to 0x040 sets every output bit that is 1 in the data, and a write to 0x060 clears every output bit that is 1 in the data. Zero bits leave their outputs unchanged. The output levels read back at 0x00 and appear on `pin_out` one cycle after the write.
- R4: A read of 0x020 returns the current level of `pin_in`.
- R5: With trigger code 1 a rising edge is detected, with code 2 a falling edge, with code 3 either edge, and with code 0 nothing. A detected edge sets the pin's status bit at the first clock edge that samples the new input level.
- R6: Writing 1 to a status bit at 0x080 clears it, and writing 0 leaves it alone. An edge that is detected in the same cycle as the clearing write leaves the bit set.
- R7: Writing 1 to a bit at 0x0A0 masks that pin, and writing 1 to a bit at 0x0C0 unmasks it. Status bits are set by edges whether or not the pin is masked.
- R8: `irq` is high exactly when some status bit is set and its mask bit is clear.
- R9: While `wr_unlock` is low, writes to any register have no effect.
- R10: Writing all ones to 0x0A0 and then to 0x080 leaves every pin masked and every status bit cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_unlock | input | 1 | Bank write-enable from the lock unit |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 9 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Synchronised pin input levels |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output enable per pin (1 = driving) |
| irq | output | 1 | Combined bank interrupt |

## Verification
The bench moves several pins at once with different trigger codes. A decoder that swaps the rising and falling codes, or that ignores code 0, therefore leaves a wrong status pattern.

It writes zeros to the set, clear and status registers. A design that loads those registers instead of using write-one semantics would lose bits. It also lets an edge and a clearing write land in the same cycle. A design that gives the clear priority would drop that edge.

Finally, the bench writes while the bank is locked, and checks that the interrupt follows the mask in both directions. A design that ignores the lock, or that gates status with the mask instead of gating only the interrupt, is caught.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  localparam int unsigned AW = 9;

  typedef enum logic [1:0] {
    TRG_OFF  = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_BOTH = 2'd3
  } trig_e;

  localparam logic [AW-1:0] OFS_OUT_LVL = 9'h000;
  localparam logic [AW-1:0] OFS_IN_LVL  = 9'h020;
  localparam logic [AW-1:0] OFS_OUT_SET = 9'h040;
  localparam logic [AW-1:0] OFS_OUT_CLR = 9'h060;
  localparam logic [AW-1:0] OFS_STS     = 9'h080;
  localparam logic [AW-1:0] OFS_MSK_SET = 9'h0A0;
  localparam logic [AW-1:0] OFS_MSK_CLR = 9'h0C0;
  localparam logic [AW-1:0] OFS_CTL     = 9'h100;

  // control word layout
  localparam int unsigned CTL_DIR_BIT = 0;
  localparam int unsigned CTL_TRG_LSB = 3;

  typedef struct packed {
    logic out_set;
    logic out_clr;
    logic sts_clr;
    logic msk_set;
    logic msk_clr;
    logic ctl;
  } wstb_t;

endpackage

// File: rtl/gpb_decode.sv
module gpb_decode
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  localparam int unsigned IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic          bus_wr,
  input  logic          wr_unlock,
  input  logic [AW-1:0] bus_addr,
  output wstb_t         stb_o,
  output logic          ctl_hit_o,
  output logic [IW-1:0] ctl_idx_o
);

  logic          wen;
  logic [AW-1:0] ctl_off;
  logic [AW-1:0] ctl_word;

  always_comb begin
    wen       = bus_wr & wr_unlock;
    ctl_off   = bus_addr - OFS_CTL;
    ctl_word  = ctl_off >> 2;
    ctl_hit_o = (bus_addr >= OFS_CTL) && (ctl_word < AW'(NPINS))
                && (bus_addr[1:0] == 2'b00);
    ctl_idx_o = ctl_word[IW-1:0];

    stb_o.out_set = wen && (bus_addr == OFS_OUT_SET);
    stb_o.out_clr = wen && (bus_addr == OFS_OUT_CLR);
    stb_o.sts_clr = wen && (bus_addr == OFS_STS);
    stb_o.msk_set = wen && (bus_addr == OFS_MSK_SET);
    stb_o.msk_clr = wen && (bus_addr == OFS_MSK_CLR);
    stb_o.ctl     = wen && ctl_hit_o;
  end

endmodule

// File: rtl/gpb_edge.sv
module gpb_edge
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      pin_in,
  input  logic [NPINS-1:0][1:0] trig_i,
  output logic [NPINS-1:0]      edge_o
);

  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] pin_d;

  always_comb pin_d = pin_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic rise, fall;
    always_comb begin
      rise = pin_in[p] & ~pin_q[p];
      fall = ~pin_in[p] & pin_q[p];
      unique case (trig_e'(trig_i[p]))
        TRG_RISE: edge_o[p] = rise;
        TRG_FALL: edge_o[p] = fall;
        TRG_BOTH: edge_o[p] = rise | fall;
        default:  edge_o[p] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpb_irq.sv
module gpb_irq #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] edge_i,
  input  logic             sts_clr_i,
  input  logic             msk_set_i,
  input  logic             msk_clr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] status_o,
  output logic [NPINS-1:0] mask_o,
  output logic             irq_o
);

  logic [NPINS-1:0] sts_q, sts_d;
  logic [NPINS-1:0] msk_q, msk_d;

  always_comb begin
    sts_d = sts_q;
    if (sts_clr_i) sts_d = sts_d & ~wdata_i;
    sts_d = sts_d | edge_i;              // new edge wins over a clear
    msk_d = msk_q;
    if (msk_set_i) msk_d = msk_d | wdata_i;
    if (msk_clr_i) msk_d = msk_d & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '1;
    end else begin
      sts_q <= sts_d;
      msk_q <= msk_d;
    end
  end

  assign status_o = sts_q;
  assign mask_o   = msk_q;
  assign irq_o    = |(sts_q & ~msk_q);

  p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i != '0) |=> ((sts_q & $past(edge_i)) == $past(edge_i)));

  p_no_spont_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(edge_i)) == '0));

  p_all_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '1) |-> !irq_o);

  p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sts_q != '0));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpb_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_unlock,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);

  wstb_t                 stb;
  logic                  ctl_hit;
  logic [IW-1:0]         ctl_idx;
  logic [NPINS-1:0]      wd;
  logic [NPINS-1:0]      out_q, out_d;
  logic [NPINS-1:0]      dir_q, dir_d;
  logic [NPINS-1:0][1:0] trig_q, trig_d;
  logic [NPINS-1:0]      edge_hit;
  logic [NPINS-1:0]      status, mask;

  assign wd = bus_wdata[NPINS-1:0];

  gpb_decode #(.NPINS(NPINS)) u_dec (
    .bus_wr    (bus_wr),
    .wr_unlock (wr_unlock),
    .bus_addr  (bus_addr),
    .stb_o     (stb),
    .ctl_hit_o (ctl_hit),
    .ctl_idx_o (ctl_idx)
  );

  gpb_edge #(.NPINS(NPINS)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .trig_i (trig_q),
    .edge_o (edge_hit)
  );

  gpb_irq #(.NPINS(NPINS)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_i    (edge_hit),
    .sts_clr_i (stb.sts_clr),
    .msk_set_i (stb.msk_set),
    .msk_clr_i (stb.msk_clr),
    .wdata_i   (wd),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq)
  );

  // next state of output levels and per-pin control
  always_comb begin
    out_d = out_q;
    if (stb.out_set) out_d = out_d | wd;
    if (stb.out_clr) out_d = out_d & ~wd;
    dir_d  = dir_q;
    trig_d = trig_q;
    if (stb.ctl) begin
      dir_d[ctl_idx]  = bus_wdata[CTL_DIR_BIT];
      trig_d[ctl_idx] = bus_wdata[CTL_TRG_LSB +: 2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      trig_q <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      trig_q <= trig_d;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (ctl_hit) begin
      bus_rdata[CTL_DIR_BIT]      = dir_q[ctl_idx];
      bus_rdata[CTL_TRG_LSB +: 2] = trig_q[ctl_idx];
    end else begin
      case (bus_addr)
        OFS_OUT_LVL: bus_rdata[NPINS-1:0] = out_q;
        OFS_IN_LVL:  bus_rdata[NPINS-1:0] = pin_in;
        OFS_STS:     bus_rdata[NPINS-1:0] = status;
        OFS_MSK_SET: bus_rdata[NPINS-1:0] = mask;
        default:     bus_rdata = '0;
      endcase
    end
  end

  p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.out_set |=> ((pin_out & $past(wd)) == $past(wd)));

  p_out_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.out_clr |=> ((pin_out & $past(wd)) == '0));

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_unlock |=> ($stable(pin_out) && $stable(pin_oe)));

  p_lock_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_unlock |=> $stable(mask));

endmodule

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;

  localparam int OP_WR = 0, OP_RD = 1, OP_PIN = 2, OP_IRQ = 3;
  localparam int VW = 79;
  localparam int NV = 42;

  // {op, addr, data, expected, requirement}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd1, 9'h0A0, 32'h0, 32'hFFFFFFFF, 4'd1},  // R1 mask all ones
    {2'd1, 9'h080, 32'h0, 32'h0,        4'd1},  // R1 status clear
    {2'd1, 9'h000, 32'h0, 32'h0,        4'd1},  // R1 outputs low
    {2'd1, 9'h100, 32'h0, 32'h1,        4'd1},  // R1 input, trig off
    {2'd3, 9'h000, 32'h0, 32'h0,        4'd1},  // R1 irq low
    {2'd0, 9'h10C, 32'h0, 32'h0,        4'd2},  // R2 pin3 output
    {2'd1, 9'h10C, 32'h0, 32'h0,        4'd2},
    {2'd0, 9'h040, 32'h9, 32'h0,        4'd3},  // R3 set
    {2'd1, 9'h000, 32'h0, 32'h9,        4'd3},
    {2'd0, 9'h060, 32'h1, 32'h0,        4'd3},  // R3 clear
    {2'd1, 9'h000, 32'h0, 32'h8,        4'd3},
    {2'd0, 9'h040, 32'h0, 32'h0,        4'd3},  // R3 zeros no effect
    {2'd0, 9'h060, 32'h0, 32'h0,        4'd3},
    {2'd1, 9'h000, 32'h0, 32'h8,        4'd3},
    {2'd2, 9'h000, 32'hF0, 32'h0,       4'd4},  // R4 pin levels
    {2'd1, 9'h020, 32'h0, 32'hF0,       4'd4},
    {2'd1, 9'h080, 32'h0, 32'h0,        4'd5},  // R5 trig off
    {2'd0, 9'h104, 32'h09, 32'h0,       4'd5},  // pin1 rising
    {2'd0, 9'h108, 32'h11, 32'h0,       4'd5},  // pin2 falling
    {2'd0, 9'h114, 32'h19, 32'h0,       4'd5},  // pin5 both
    {2'd1, 9'h104, 32'h0, 32'h09,       4'd2},  // R2 readback
    {2'd2, 9'h000, 32'h06, 32'h0,       4'd5},
    {2'd1, 9'h080, 32'h0, 32'h22,       4'd5},  // R5 + R7 masked edge
    {2'd3, 9'h000, 32'h0, 32'h0,        4'd7},
    {2'd2, 9'h000, 32'h20, 32'h0,       4'd5},
    {2'd1, 9'h080, 32'h0, 32'h26,       4'd5},
    {2'd0, 9'h0C0, 32'h4, 32'h0,        4'd7},  // R7 unmask pin2
    {2'd1, 9'h0A0, 32'h0, 32'hFFFFFFFB, 4'd7},
    {2'd3, 9'h000, 32'h0, 32'h1,        4'd8},  // R8
    {2'd0, 9'h080, 32'h4, 32'h0,        4'd6},  // R6 clear pin2
    {2'd1, 9'h080, 32'h0, 32'h22,       4'd6},
    {2'd3, 9'h000, 32'h0, 32'h0,        4'd8},
    {2'd0, 9'h080, 32'h0, 32'h0,        4'd6},  // R6 zeros
    {2'd1, 9'h080, 32'h0, 32'h22,       4'd6},
    {2'd0, 9'h0C0, 32'h2, 32'h0,        4'd7},
    {2'd3, 9'h000, 32'h0, 32'h1,        4'd8},
    {2'd0, 9'h0A0, 32'h2, 32'h0,        4'd7},
    {2'd3, 9'h000, 32'h0, 32'h0,        4'd8},
    {2'd0, 9'h0A0, 32'hFFFFFFFF, 32'h0, 4'd10}, // R10
    {2'd0, 9'h080, 32'hFFFFFFFF, 32'h0, 4'd10},
    {2'd1, 9'h0A0, 32'h0, 32'hFFFFFFFF, 4'd10},
    {2'd1, 9'h080, 32'h0, 32'h0,        4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_unlock;
  logic        bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_unlock (wr_unlock),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input int req, input logic [8:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 check(req, bus_rdata, exp);
  endtask

  task automatic do_pin(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_unlock = 1'b1; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [8:0]  a;
      logic [31:0] d, e;
      logic [3:0]  r;
      {op, a, d, e, r} = VEC[i];
      case (int'(op))
        OP_WR:  do_wr(a, d);
        OP_RD:  do_rd(int'(r), a, e);
        OP_PIN: do_pin(d);
        default: begin
          @(negedge clk);
          #1 check(int'(r), {31'b0, irq}, e);
        end
      endcase
    end

    // R2: only pin3 drives, at level high
    @(negedge clk);
    check(2, pin_oe, 32'h8);
    check(3, pin_out, 32'h8);

    // R9: locked bank ignores writes
    wr_unlock = 1'b0;
    do_wr(9'h040, 32'hFFFFFFFF);
    do_wr(9'h10C, 32'h1);
    do_wr(9'h0C0, 32'hFFFFFFFF);
    @(negedge clk);
    check(9, pin_out, 32'h8);
    check(9, pin_oe, 32'h8);
    do_rd(9, 9'h0A0, 32'hFFFFFFFF);
    wr_unlock = 1'b1;

    // R6: rising edge on pin1 in the same cycle as its clear
    @(negedge clk);
    pin_in = 32'h22;
    bus_wr = 1'b1; bus_addr = 9'h080; bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0;
    do_rd(6, 9'h080, 32'h2);
    do_wr(9'h080, 32'h2);
    do_rd(6, 9'h080, 32'h0);

    // R5: code 0 again disables pin5 detection
    do_wr(9'h114, 32'h1);
    do_pin(32'h02);
    do_rd(5, 9'h080, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule